// File: doc/BRIEF.md
# Nearest-Neighbor Coefficient Loader

This sequencer prepares a video scaler for nearest-neighbor filtering. On a start pulse it captures the requested mode. It then drives a simple register-write master port with a fixed series of writes.

In nearest-neighbor mode the series has four parts:
- the coefficient index register is armed with auto-increment;
- 60 packed coefficient dwords go to the data register, covering 17 phases of 7 taps;
- the index register is cleared;
- the control register is written with scaler enable and with the programmed filter on coefficient set 0.

In default mode the loader does not touch the coefficient memory. It only writes the control register, selecting the built-in medium filter.

The coefficient table is not stored anywhere. A tap counter that steps by two modulo the tap count builds each dword as it is needed. Every tap other than the centre tap carries the "zero" code, and the centre tap carries the "one" code.

Top module: `nnl_coef_loader`

## Requirements
- R1: After reset, `wr_valid_o`, `busy_o` and `done_o` are low.
- R2: In nearest-neighbor mode the first write goes to the index address (8'h20) with data 32'h0000_0400 (bit 10 = auto-increment, index 0).
- R3: The index write is followed by exactly 60 writes to the data address (8'h24).
- R4: Coefficient k of the stream (k = 0..119) has tap number k mod 7. Tap 3 is encoded 16'h0800 and every other tap 16'h3000, including the unused slot for k = 119.
- R5: Data dword j carries coefficient 2j in bits [15:0] and coefficient 2j+1 in bits [31:16].
- R6: After the last data dword, the index address is written with 32'h0.
- R7: A nearest-neighbor run ends with a write of 32'h8100_0000 to the control address (8'h00). Bit 31 is enable. Bits [24:23] = 2'b10 select programmed filtering. The four 2-bit set fields in bits [15:8] (luma vertical, luma horizontal, chroma vertical, chroma horizontal) are all 0.
- R8: A default-mode run issues only one write: 32'h8080_0000 to the control address, where bits [24:23] = 2'b01 select the medium filter.
- R9: While `wr_valid_o` is high and `wr_ready_i` is low, the write is held: valid stays high and address and data are unchanged on the next cycle.
- R10: `busy_o` and `wr_valid_o` rise the cycle after an accepted start. They fall in the cycle after the control write is accepted, and `done_o` is high for exactly that one cycle.
- R11: `start_i` is ignored while busy. The mode is taken from `nearest_i` in the start cycle, and later changes to `nearest_i` do not alter the running series.
- R12: A start seen in the cycle where `done_o` is high begins a new run immediately.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, taken when idle |
| nearest_i | input | 1 | 1 = nearest-neighbor load, 0 = default medium filter |
| wr_valid_o | output | 1 | Register write pending |
| wr_addr_o | output | 8 | Register write address |
| wr_data_o | output | 32 | Register write data |
| wr_ready_i | input | 1 | Write accepted when high together with valid |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle pulse after the control write is accepted |

## Verification
Two functions can fall in the same cycle: the completion pulse of one run and the start of the next. The bench holds `start_i` high through the cycle in which `done_o` pulses. The reference model must then see the next run's first write on the following cycle, with no idle gap. The bench also raises start, flips the mode and stalls `wr_ready_i` while a run is in flight, including across the last data dword. Every output is compared on every clock against a queue of expected writes, and the coefficient memory rebuilt from the accepted writes is checked tap by tap.

// File: rtl/nnl_pkg.sv
package nnl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_IDX_ON  = 3'd1,
    ST_DATA    = 3'd2,
    ST_IDX_OFF = 3'd3,
    ST_CTRL    = 3'd4
  } nnl_state_e;

  localparam logic [1:0] FILT_MEDIUM = 2'b01;
  localparam logic [1:0] FILT_PROG   = 2'b10;

endpackage

// File: rtl/nnl_coef_gen.sv
module nnl_coef_gen #(
  parameter int unsigned PHASES     = 17,
  parameter int unsigned TAPS       = 7,
  parameter int unsigned CENTER_TAP = 3,
  parameter int unsigned CW         = 16,
  parameter logic [CW-1:0] ONE_VAL  = 16'h0800,
  parameter logic [CW-1:0] ZERO_VAL = 16'h3000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear_i,
  input  logic            adv_i,
  output logic [2*CW-1:0] dword_o,
  output logic            last_o
);
  localparam int unsigned NCOEF = PHASES * TAPS;
  localparam int unsigned NDW   = (NCOEF + 1) / 2;
  localparam int unsigned TAP_W = $clog2(TAPS) + 1;
  localparam int unsigned CNT_W = $clog2(NDW);

  logic [TAP_W-1:0] tap_q, tap_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  function automatic logic [TAP_W-1:0] tap_wrap(input logic [TAP_W:0] v);
    logic [TAP_W:0] r;
    r = (v >= (TAP_W+1)'(TAPS)) ? v - (TAP_W+1)'(TAPS) : v;
    return r[TAP_W-1:0];
  endfunction

  always_comb begin
    tap_d = tap_q;
    cnt_d = cnt_q;
    if (clear_i) begin
      tap_d = '0;
      cnt_d = '0;
    end else if (adv_i) begin
      tap_d = tap_wrap({1'b0, tap_q} + (TAP_W+1)'(2));
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tap_q <= '0;
      cnt_q <= '0;
    end else if (clear_i || adv_i) begin
      tap_q <= tap_d;
      cnt_q <= cnt_d;
    end
  end

  for (genvar h = 0; h < 2; h++) begin : g_half
    logic [TAP_W-1:0] tap_h;
    assign tap_h = tap_wrap({1'b0, tap_q} + (TAP_W+1)'(h));
    assign dword_o[h*CW +: CW] =
      (tap_h == TAP_W'(CENTER_TAP)) ? ONE_VAL : ZERO_VAL;
  end

  assign last_o = (cnt_q == CNT_W'(NDW - 1));
endmodule

// File: rtl/nnl_ctrl_word.sv
module nnl_ctrl_word #(
  parameter int unsigned DW       = 32,
  parameter int unsigned EN_BIT   = 31,
  parameter int unsigned FILT_LSB = 23,
  parameter int unsigned SEL_LSB  = 8,
  parameter int unsigned SET_W    = 2,
  parameter int unsigned COEF_SET = 0
) (
  input  logic          prog_i,
  output logic [DW-1:0] word_o
);
  import nnl_pkg::*;
  localparam int unsigned NSEL = 4;

  logic [NSEL*SET_W-1:0] sel_bits;

  for (genvar f = 0; f < NSEL; f++) begin : g_sel
    assign sel_bits[f*SET_W +: SET_W] = prog_i ? SET_W'(COEF_SET) : '0;
  end

  always_comb begin
    word_o = '0;
    word_o[EN_BIT] = 1'b1;
    word_o[FILT_LSB +: 2] = prog_i ? FILT_PROG : FILT_MEDIUM;
    word_o[SEL_LSB +: NSEL*SET_W] = sel_bits;
  end
endmodule

// File: rtl/nnl_fsm.sv
module nnl_fsm (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic                nearest_i,
  input  logic                ready_i,
  input  logic                last_i,
  output nnl_pkg::nnl_state_e state_o,
  output logic                prog_o,
  output logic                gen_clear_o,
  output logic                gen_adv_o,
  output logic                done_o
);
  import nnl_pkg::*;

  nnl_state_e state_q, state_d;
  logic       prog_q, prog_d;
  logic       done_q, done_d;
  logic       take_start;

  assign take_start = (state_q == ST_IDLE) && start_i;

  always_comb begin
    state_d   = state_q;
    prog_d    = prog_q;
    done_d    = 1'b0;
    gen_adv_o = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          prog_d  = nearest_i;
          state_d = nearest_i ? ST_IDX_ON : ST_CTRL;
        end
      end
      ST_IDX_ON:  if (ready_i) state_d = ST_DATA;
      ST_DATA: begin
        if (ready_i) begin
          gen_adv_o = 1'b1;
          if (last_i) state_d = ST_IDX_OFF;
        end
      end
      ST_IDX_OFF: if (ready_i) state_d = ST_CTRL;
      ST_CTRL: begin
        if (ready_i) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      prog_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      if (take_start) prog_q <= prog_d;
    end
  end

  assign state_o     = state_q;
  assign prog_o      = prog_q;
  assign gen_clear_o = take_start;
  assign done_o      = done_q;
endmodule

// File: rtl/nnl_coef_loader.sv
module nnl_coef_loader #(
  parameter int unsigned AW          = 8,
  parameter int unsigned DW          = 32,
  parameter int unsigned PHASES      = 17,
  parameter int unsigned TAPS        = 7,
  parameter int unsigned CENTER_TAP  = 3,
  parameter logic [AW-1:0] IDX_ADDR  = 8'h20,
  parameter logic [AW-1:0] DATA_ADDR = 8'h24,
  parameter logic [AW-1:0] CTRL_ADDR = 8'h00,
  parameter int unsigned AUTOINC_BIT = 10,
  parameter int unsigned COEF_SET    = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          nearest_i,
  output logic          wr_valid_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o,
  input  logic          wr_ready_i,
  output logic          busy_o,
  output logic          done_o
);
  import nnl_pkg::*;
  localparam int unsigned CW = DW / 2;

  nnl_state_e    state;
  logic          prog, gen_clear, gen_adv, last;
  logic [DW-1:0] coef_dword, ctrl_word;

  nnl_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .nearest_i  (nearest_i),
    .ready_i    (wr_ready_i),
    .last_i     (last),
    .state_o    (state),
    .prog_o     (prog),
    .gen_clear_o(gen_clear),
    .gen_adv_o  (gen_adv),
    .done_o     (done_o)
  );

  nnl_coef_gen #(
    .PHASES    (PHASES),
    .TAPS      (TAPS),
    .CENTER_TAP(CENTER_TAP),
    .CW        (CW),
    .ONE_VAL   (CW'(16'h0800)),
    .ZERO_VAL  (CW'(16'h3000))
  ) u_gen (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear_i(gen_clear),
    .adv_i  (gen_adv),
    .dword_o(coef_dword),
    .last_o (last)
  );

  nnl_ctrl_word #(
    .DW      (DW),
    .COEF_SET(COEF_SET)
  ) u_ctrl (
    .prog_i(prog),
    .word_o(ctrl_word)
  );

  always_comb begin
    wr_addr_o = CTRL_ADDR;
    wr_data_o = '0;
    case (state)
      ST_IDX_ON: begin
        wr_addr_o = IDX_ADDR;
        wr_data_o[AUTOINC_BIT] = 1'b1;
      end
      ST_DATA: begin
        wr_addr_o = DATA_ADDR;
        wr_data_o = coef_dword;
      end
      ST_IDX_OFF: wr_addr_o = IDX_ADDR;
      ST_CTRL:    wr_data_o = ctrl_word;
      default:    wr_addr_o = CTRL_ADDR;
    endcase
  end

  assign wr_valid_o = (state != ST_IDLE);
  assign busy_o     = (state != ST_IDLE);
endmodule

// File: rtl/nnl_coef_loader_chk.sv
module nnl_coef_loader_chk #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_valid_o,
  input logic [AW-1:0] wr_addr_o,
  input logic [DW-1:0] wr_data_o,
  input logic          wr_ready_i,
  input logic          busy_o,
  input logic          done_o
);
  AST_RST_QUIET: assert property (@(posedge clk) !rst_n |-> !wr_valid_o && !done_o); // R1

  AST_HOLD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o && !wr_ready_i |=> wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o)); // R9

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R10

  AST_DONE_AT_BUSY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o); // R10

  AST_DONE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(wr_valid_o && wr_ready_i)); // R10

  AST_COEF_CODES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o && wr_addr_o == 8'h24 |->
      (wr_data_o[15:0] == 16'h0800 || wr_data_o[15:0] == 16'h3000) &&
      (wr_data_o[31:16] == 16'h0800 || wr_data_o[31:16] == 16'h3000)); // R4
endmodule

bind nnl_coef_loader nnl_coef_loader_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_valid_o(wr_valid_o),
  .wr_addr_o (wr_addr_o),
  .wr_data_o (wr_data_o),
  .wr_ready_i(wr_ready_i),
  .busy_o    (busy_o),
  .done_o    (done_o)
);

// File: tb/tb_nnl_coef_loader.sv
module tb_nnl_coef_loader;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n, start_i, nearest_i, wr_ready_i;
  logic        wr_valid_o, busy_o, done_o;
  logic [7:0]  wr_addr_o;
  logic [31:0] wr_data_o;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;

  nnl_coef_loader dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .nearest_i(nearest_i),
    .wr_valid_o(wr_valid_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
    .wr_ready_i(wr_ready_i), .busy_o(busy_o), .done_o(done_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [7:0]  a;
    logic [31:0] d;
    string       r;
  } wr_t;

  wr_t  exp_q[$];
  logic exp_done;
  logic [15:0] mem [0:127];
  int   mem_ptr;
  logic mem_autoinc;

  function automatic logic [15:0] coef_of(int k);
    return ((k % 7) == 3) ? 16'h0800 : 16'h3000;
  endfunction

  task automatic push_job(input logic nn);
    wr_t w;
    if (nn) begin
      w.a = 8'h20; w.d = 32'h0000_0400; w.r = "R2"; exp_q.push_back(w);
      for (int j = 0; j < 60; j++) begin
        w.a = 8'h24;
        w.d = {coef_of(2*j+1), coef_of(2*j)};
        w.r = "R3/R4/R5";
        exp_q.push_back(w);
      end
      w.a = 8'h20; w.d = 32'h0; w.r = "R6"; exp_q.push_back(w);
      w.a = 8'h00; w.d = 32'h8100_0000; w.r = "R7"; exp_q.push_back(w);
    end else begin
      w.a = 8'h00; w.d = 32'h8080_0000; w.r = "R8"; exp_q.push_back(w);
    end
  endtask

  // Reference model: advances on each clock from the inputs alone.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_q.delete();
      exp_done <= 1'b0;
    end else begin
      exp_done <= 1'b0;
      if (exp_q.size() > 0) begin
        if (wr_ready_i) begin
          void'(exp_q.pop_front());
          if (exp_q.size() == 0) exp_done <= 1'b1;
        end
      end else if (start_i) begin
        push_job(nearest_i); // R11: mode taken in the start cycle
      end
    end
  end

  // Coefficient memory: rebuilt from accepted writes only.
  always @(posedge clk) begin
    if (rst_n && wr_valid_o && wr_ready_i) begin
      if (wr_addr_o == 8'h20) begin
        mem_ptr     = int'(wr_data_o[9:0]);
        mem_autoinc = wr_data_o[10];
      end else if (wr_addr_o == 8'h24) begin
        mem[mem_ptr]   = wr_data_o[15:0];
        mem[mem_ptr+1] = wr_data_o[31:16];
        if (mem_autoinc) mem_ptr = mem_ptr + 2;
      end
    end
  end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] expv);
    vectors++;
    if (act !== expv) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h at cycle %0d", r, act, expv, cycles);
    end
  endtask

  logic       prev_hold;
  logic [7:0] prev_a;
  logic [31:0] prev_d;

  // Compare on every clock, away from the active edge.
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      chk("R10 busy", {31'b0, busy_o}, {31'b0, exp_q.size() > 0});
      chk("R10 valid", {31'b0, wr_valid_o}, {31'b0, exp_q.size() > 0});
      chk("R10 done", {31'b0, done_o}, {31'b0, exp_done});
      if (exp_q.size() > 0 && wr_valid_o) begin
        chk({exp_q[0].r, " addr"}, {24'b0, wr_addr_o}, {24'b0, exp_q[0].a});
        chk({exp_q[0].r, " data"}, wr_data_o, exp_q[0].d);
      end
      if (prev_hold) begin
        chk("R9 held addr", {24'b0, wr_addr_o}, {24'b0, prev_a});
        chk("R9 held data", wr_data_o, prev_d);
      end
      prev_hold = wr_valid_o && !wr_ready_i;
      prev_a = wr_addr_o;
      prev_d = wr_data_o;
    end else begin
      prev_hold = 1'b0;
    end
  end

  task automatic wait_done();
    do @(negedge clk); while (!done_o);
  endtask

  task automatic check_mem();
    for (int k = 0; k < 119; k++)
      chk("R4/R5 mem", {16'b0, mem[k]}, {16'b0, coef_of(k)});
    chk("R6 index cleared", mem_ptr, 0);
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; nearest_i = 1'b0; wr_ready_i = 1'b1;
    prev_hold = 1'b0; mem_ptr = 0; mem_autoinc = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 valid", {31'b0, wr_valid_o}, 32'h0);
    chk("R1 busy", {31'b0, busy_o}, 32'h0);
    chk("R1 done", {31'b0, done_o}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // Nearest-neighbor run, always ready (R2..R7).
    for (int k = 0; k < 128; k++) mem[k] = 16'hdead;
    start_i = 1'b1; nearest_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wait_done();
    check_mem();

    // Default-mode run (R8).
    repeat (2) @(negedge clk);
    start_i = 1'b1; nearest_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    wait_done();

    // Nearest run with stalls, stray starts and mode flips (R9, R11).
    for (int k = 0; k < 128; k++) mem[k] = 16'hdead;
    start_i = 1'b1; nearest_i = 1'b1;
    @(negedge clk);
    for (int c = 0; !done_o && c < 2000; c++) begin
      wr_ready_i = ((c % 3) != 1) && ((c % 11) != 5);
      start_i    = (c % 4) == 2;
      nearest_i  = (c % 5) < 2;
      @(negedge clk);
    end
    start_i = 1'b0; wr_ready_i = 1'b1;
    check_mem();

    // Start held through the done cycle (R12): default then nearest.
    repeat (2) @(negedge clk);
    start_i = 1'b1; nearest_i = 1'b0;
    wait_done();
    nearest_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk("R12 back-to-back busy", {31'b0, busy_o}, 32'h1);
    wait_done();
    repeat (3) @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule